// File: doc/BRIEF.md
# Loop Tune-and-Settle Sequencer

This block paces the start-up of three frequency-synthesis loops: two RF loops and one IF loop. Each loop has its own reference divider. The divider counts reference-clock enable pulses and emits one update tick every R pulses, or every 2R pulses when the half-rate option is on. A loop's sequencer counts these ticks through three timed phases:

- a self-tune window of 13 ticks;
- a settling window of 25 ticks;
- a locked phase that lasts until the next trigger.

A loop is triggered when its section enable turns on. It is also triggered when a register-change pulse arrives while the loop is enabled. A disabled loop goes back to idle and clears its counters.

The block produces three kinds of output. Each loop reports its phase code and a ready flag. One active-low lock indicator is shared by all loops. It goes high while any loop is self-tuning, or while an active loop reports that it is close to the edge of its compensation range. An R value below the minimum allowed by the loop's 2-bit gain setting is raised to that minimum before it is used.

Top module: `pll_settle_seq`

## Requirements
- R1: After reset every loop reports phase code 00 (idle), every ready flag is 0 and lock_det_n is 0.
- R2: A loop's update tick fires once every R_eff reference-enable pulses, or every 2*R_eff pulses when half_rate is 1. Cycles with ref_en low do not advance the divider.
- R3: R_eff is the programmed R, raised to a minimum of 7, 8, 10 or 14 when the loop's gain code is 0, 1, 2 or 3.
- R4: An idle loop whose enable is 1 enters self-tune (phase code 01) on the next clock edge.
- R5: Self-tune lasts exactly 13 ticks. With ref_en high every cycle, phase code 10 (settle) first appears 1+13*R_div edges after enable, where R_div = R_eff, or 2*R_eff when half_rate is 1.
- R6: Settling lasts exactly 25 ticks. Phase code 11 (locked) and ready=1 first appear 1+38*R_div edges after enable.
- R7: A reprog pulse on an enabled loop sends it to self-tune on the next edge and clears ready. The loop then locks again 38*R_div edges later. A reprog pulse on a disabled loop is ignored.
- R8: Clearing a loop's enable returns it to idle with ready=0 on the next edge, whatever phase it was in.
- R9: lock_det_n is 1 whenever any loop is in self-tune, and 0 once no loop is tuning and no near-limit flag applies.
- R10: lock_det_n is 1 while a non-idle loop has near_limit set. The near_limit flag of an idle or disabled loop has no effect.
- R11: The loops run independently: each one's timing depends only on its own R, gain, enable and reprog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle pulse per reference-clock period |
| half_rate | input | 1 | Extra divide by 2 ahead of every R divider |
| loop_en | input | 3 | Per-loop section enable (0 = RF1, 1 = RF2, 2 = IF) |
| reprog | input | 3 | Per-loop register-change pulse |
| r_val | input | 3x13 | Per-loop programmed R value |
| gain | input | 3x2 | Per-loop phase-detector gain code |
| near_limit | input | 3 | Per-loop near-compensation-limit flag |
| loop_phase | output | 3x2 | Per-loop phase: 00 idle, 01 tune, 10 settle, 11 locked |
| ready | output | 3 | Per-loop settled flag |
| lock_det_n | output | 1 | Combined active-low lock indicator |

## Verification
The bench measures the exact edge at which each loop enters settle and reaches lock. It does this for every gain-code clamp, for the half-rate divide and for each loop. A design that counted 12 or 14 tune ticks, was off by one in the R divider, or failed to clamp would miss those edges. Directed cases cover the following:

- a reprog pulse in the locked phase, which a design that ignored it would leave locked;
- a stalled reference, which must freeze progress;
- a mid-run disable, which must drop ready at once;
- near-limit flags on active loops, which must raise the indicator, and on disabled loops, which must not.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'b00,
      PH_TUNE   = 2'b01,
      PH_SETTLE = 2'b10,
      PH_LOCK   = 2'b11
   } phase_e;

   localparam int GAIN_W = 2;

   // smallest usable divider value for each gain code
   localparam int R_MIN_TAB [4] = '{7, 8, 10, 14};

endpackage

// File: rtl/pllseq_tick_div.sv
module pllseq_tick_div
   import pllseq_pkg::*;
#(
   parameter int R_W          = 13,
   parameter bit USE_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              ref_en,
   input  logic              half_rate,
   input  logic [R_W-1:0]    r_val,
   input  logic [GAIN_W-1:0] gain,
   output logic              tick
);

   logic [R_W-1:0] r_min;
   logic [R_W-1:0] r_eff;
   logic [R_W-1:0] cnt;
   logic           beat;
   logic           last;

   // raise a too-small divider to the floor for its gain code (R3)
   always_comb begin
      r_min = R_W'(R_MIN_TAB[gain]);
      r_eff = (r_val < r_min) ? r_min : r_val;
   end

   generate
      if (USE_PRESCALE) begin : g_pre
         logic half_ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  half_ph <= 1'b0;
            else if (clear || !half_rate) half_ph <= 1'b0;
            else if (ref_en)             half_ph <= ~half_ph;
         end
         assign beat = ref_en & (~half_rate | half_ph);
      end else begin : g_nopre
         assign beat = ref_en;
      end
   endgenerate

   assign last = (cnt >= r_eff - R_W'(1));
   assign tick = beat & last & ~clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (beat)   cnt <= last ? '0 : cnt + R_W'(1);
   end

   // R2: without a beat the divider holds its count
   a_r2_hold_without_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat && !clear) |=> $stable(cnt));

   // R2: every tick starts a fresh period
   a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));

endmodule

// File: rtl/pllseq_seq_fsm.sv
module pllseq_seq_fsm
   import pllseq_pkg::*;
#(
   parameter int TUNE_TICKS   = 13,
   parameter int SETTLE_TICKS = 25
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       restart,
   input  logic       tick,
   output logic [1:0] phase_o,
   output logic       ready,
   output logic       div_clear
);

   localparam int MAXT = (TUNE_TICKS > SETTLE_TICKS) ? TUNE_TICKS : SETTLE_TICKS;
   localparam int CW   = $clog2(MAXT + 1);

   phase_e        state, state_nx;
   logic [CW-1:0] tcnt, tcnt_nx;

   always_comb begin
      state_nx = state;
      tcnt_nx  = tcnt;
      if (!enable) begin
         state_nx = PH_IDLE;
         tcnt_nx  = '0;
      end else if (restart) begin
         state_nx = PH_TUNE;
         tcnt_nx  = '0;
      end else begin
         unique case (state)
            PH_IDLE: begin
               state_nx = PH_TUNE;
               tcnt_nx  = '0;
            end
            PH_TUNE: if (tick) begin
               if (tcnt == CW'(TUNE_TICKS - 1)) begin
                  state_nx = PH_SETTLE;
                  tcnt_nx  = '0;
               end else begin
                  tcnt_nx = tcnt + CW'(1);
               end
            end
            PH_SETTLE: if (tick) begin
               if (tcnt == CW'(SETTLE_TICKS - 1)) begin
                  state_nx = PH_LOCK;
                  tcnt_nx  = '0;
               end else begin
                  tcnt_nx = tcnt + CW'(1);
               end
            end
            PH_LOCK: tcnt_nx = '0;
            default: begin
               state_nx = PH_IDLE;
               tcnt_nx  = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PH_IDLE;
         tcnt  <= '0;
      end else begin
         state <= state_nx;
         tcnt  <= tcnt_nx;
      end
   end

   assign phase_o   = state;
   assign ready     = (state == PH_LOCK);
   assign div_clear = ~enable | restart | (state == PH_IDLE);

   // R8: disable forces idle on the next edge
   a_r8_off_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (phase_o == 2'b00 && !ready));

   // R7: a change pulse on an enabled loop restarts self-tune
   a_r7_restart_tune: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && restart) |=> (phase_o == 2'b01 && !ready));

   // R6: ready only rises out of the settle phase
   a_r6_ready_from_settle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(phase_o) == 2'b10));

   // R5: tune never jumps straight to lock
   a_r5_tune_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 2'b01) |=> (phase_o != 2'b11));

   // R2: without a tick an active loop keeps its phase
   a_r2_phase_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !restart && !tick && phase_o != 2'b00) |=> $stable(phase_o));

endmodule

// File: rtl/pllseq_lock_merge.sv
module pllseq_lock_merge
   import pllseq_pkg::*;
#(
   parameter int N_LOOPS = 3
) (
   input  logic [N_LOOPS-1:0][1:0] phases,
   input  logic [N_LOOPS-1:0]      near_limit,
   output logic                    lock_det_n
);

   logic [N_LOOPS-1:0] tuning;
   logic [N_LOOPS-1:0] edge_hit;

   generate
      for (genvar g = 0; g < N_LOOPS; g++) begin : g_lp
         assign tuning[g]   = (phases[g] == PH_TUNE);
         assign edge_hit[g] = near_limit[g] & (phases[g] != PH_IDLE);
      end
   endgenerate

   assign lock_det_n = (|tuning) | (|edge_hit);

endmodule

// File: rtl/pll_settle_seq.sv
module pll_settle_seq
   import pllseq_pkg::*;
#(
   parameter int N_LOOPS      = 3,
   parameter int R_W          = 13,
   parameter int TUNE_TICKS   = 13,
   parameter int SETTLE_TICKS = 25,
   parameter bit USE_PRESCALE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ref_en,
   input  logic                         half_rate,
   input  logic [N_LOOPS-1:0]           loop_en,
   input  logic [N_LOOPS-1:0]           reprog,
   input  logic [N_LOOPS-1:0][R_W-1:0]  r_val,
   input  logic [N_LOOPS-1:0][1:0]      gain,
   input  logic [N_LOOPS-1:0]           near_limit,
   output logic [N_LOOPS-1:0][1:0]      loop_phase,
   output logic [N_LOOPS-1:0]           ready,
   output logic                         lock_det_n
);

   generate
      if (N_LOOPS < 1)       begin : g_bad_n  $error("N_LOOPS must be at least 1"); end
      if (R_W < 4)           begin : g_bad_rw $error("R_W too small for minimum R"); end
      if (TUNE_TICKS < 1)    begin : g_bad_t  $error("TUNE_TICKS must be positive"); end
      if (SETTLE_TICKS < 1)  begin : g_bad_s  $error("SETTLE_TICKS must be positive"); end
   endgenerate

   logic [N_LOOPS-1:0] tick;
   logic [N_LOOPS-1:0] clr;

   generate
      for (genvar l = 0; l < N_LOOPS; l++) begin : g_loop
         pllseq_tick_div #(
            .R_W          (R_W),
            .USE_PRESCALE (USE_PRESCALE)
         ) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (clr[l]),
            .ref_en    (ref_en),
            .half_rate (half_rate),
            .r_val     (r_val[l]),
            .gain      (gain[l]),
            .tick      (tick[l])
         );

         pllseq_seq_fsm #(
            .TUNE_TICKS   (TUNE_TICKS),
            .SETTLE_TICKS (SETTLE_TICKS)
         ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (loop_en[l]),
            .restart   (reprog[l]),
            .tick      (tick[l]),
            .phase_o   (loop_phase[l]),
            .ready     (ready[l]),
            .div_clear (clr[l])
         );
      end
   endgenerate

   pllseq_lock_merge #(.N_LOOPS(N_LOOPS)) u_merge (
      .phases     (loop_phase),
      .near_limit (near_limit),
      .lock_det_n (lock_det_n)
   );

   // R9: a tuning loop always shows on the lock indicator
   a_r9_tune_flags_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_phase[0] == 2'b01) |-> lock_det_n);

   // R1: nothing is ready right after reset release
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (ready == '0));

   // R4: an enabled idle loop starts tuning on the next edge
   a_r4_start_tune: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en[0] && loop_phase[0] == 2'b00) |=> (loop_phase[0] == 2'b01));

endmodule

// File: tb/pll_settle_seq_bench.sv
module pll_settle_seq_bench;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ref_en = 1'b0;
   logic             half_rate = 1'b0;
   logic [2:0]       loop_en = '0;
   logic [2:0]       reprog = '0;
   logic [2:0][12:0] r_val = '0;
   logic [2:0][1:0]  gain = '0;
   logic [2:0]       near_limit = '0;
   logic [2:0][1:0]  loop_phase;
   logic [2:0]       ready;
   logic             lock_det_n;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   int nset [3];
   int nrdy [3];
   int lock_first;
   int lock_at_set;

   always #4 clk = ~clk;

   pll_settle_seq u_pll_settle_seq (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .half_rate(half_rate),
      .loop_en(loop_en), .reprog(reprog), .r_val(r_val), .gain(gain),
      .near_limit(near_limit), .loop_phase(loop_phase), .ready(ready),
      .lock_det_n(lock_det_n)
   );

   // vector table: loop, R, gain, half_rate, expected R_div
   localparam int NV = 8;
   localparam int V_LOOP [NV] = '{0, 1, 2, 0, 1, 2, 0, 1};
   localparam int V_R    [NV] = '{7, 3, 3, 9, 9, 5, 20, 12};
   localparam int V_G    [NV] = '{0, 0, 3, 2, 1, 1, 0, 3};
   localparam int V_D    [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};
   localparam int V_RD   [NV] = '{7, 7, 14, 10, 9, 16, 40, 14};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         finish_run();
      end
   end

   // count edges until every watched loop is ready or the limit runs out
   task automatic run_until(input int maxn, input logic [2:0] watch, input int wl);
      int n = 0;
      for (int i = 0; i < 3; i++) begin
         nset[i] = -1;
         nrdy[i] = -1;
      end
      lock_first  = -1;
      lock_at_set = -1;
      while (n < maxn) begin
         @(posedge clk);
         @(negedge clk);
         n++;
         if (n == 1) lock_first = int'(lock_det_n);
         for (int i = 0; i < 3; i++) begin
            if (nset[i] < 0 && loop_phase[i] == 2'b10) begin
               nset[i] = n;
               if (i == wl) lock_at_set = int'(lock_det_n);
            end
            if (nrdy[i] < 0 && ready[i]) nrdy[i] = n;
         end
         if (((watch & ready) == watch)) break;
      end
   endtask

   task automatic all_off();
      @(negedge clk);
      loop_en = '0; reprog = '0; near_limit = '0; half_rate = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      ref_en = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(loop_phase == '0, "R1 phase", int'(loop_phase), 0);
      chk(ready == '0, "R1 ready", int'(ready), 0);
      chk(lock_det_n == 1'b0, "R1 lock_det_n", int'(lock_det_n), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R5 R6 R9 per loop
      for (int v = 0; v < NV; v++) begin
         all_off();
         r_val[V_LOOP[v]] = 13'(V_R[v]);
         gain[V_LOOP[v]]  = 2'(V_G[v]);
         half_rate        = V_D[v][0];
         loop_en[V_LOOP[v]] = 1'b1;
         run_until(1 + 38 * V_RD[v] + 20, 3'(1 << V_LOOP[v]), V_LOOP[v]);
         chk(lock_first == 1, "R4/R9 tune at first edge", lock_first, 1);
         chk(nset[V_LOOP[v]] == 1 + 13 * V_RD[v], "R5/R3/R2 settle edge",
             nset[V_LOOP[v]], 1 + 13 * V_RD[v]);
         chk(lock_at_set == 0, "R9 lock low after tune", lock_at_set, 0);
         chk(nrdy[V_LOOP[v]] == 1 + 38 * V_RD[v], "R6 ready edge",
             nrdy[V_LOOP[v]], 1 + 38 * V_RD[v]);
      end

      // R7: restart from locked
      all_off();
      r_val[0] = 13'd7; gain[0] = 2'd0; loop_en[0] = 1'b1;
      run_until(400, 3'b001, 0);
      chk(ready[0] == 1'b1, "R7 locked before pulse", int'(ready[0]), 1);
      reprog[0] = 1'b1;
      @(negedge clk);
      reprog[0] = 1'b0;
      chk(loop_phase[0] == 2'b01, "R7 back to tune", int'(loop_phase[0]), 1);
      chk(ready[0] == 1'b0, "R7 ready dropped", int'(ready[0]), 0);
      run_until(400, 3'b001, 0);
      chk(nrdy[0] == 38 * 7, "R7 relock edge", nrdy[0], 38 * 7);

      // R10: near limit on active locked loop raises indicator
      near_limit[0] = 1'b1;
      #1;
      chk(lock_det_n == 1'b1, "R10 near limit active", int'(lock_det_n), 1);
      near_limit[0] = 1'b0;
      #1;
      chk(lock_det_n == 1'b0, "R10 indicator clears", int'(lock_det_n), 0);
      // R10: disabled loop's flag ignored
      near_limit[1] = 1'b1;
      #1;
      chk(lock_det_n == 1'b0, "R10 idle loop ignored", int'(lock_det_n), 0);
      near_limit[1] = 1'b0;

      // R8: disable while locked
      @(negedge clk);
      loop_en[0] = 1'b0;
      @(negedge clk);
      chk(loop_phase[0] == 2'b00, "R8 idle after disable", int'(loop_phase[0]), 0);
      chk(ready[0] == 1'b0, "R8 ready low", int'(ready[0]), 0);

      // R7: reprog on disabled loop ignored
      reprog[0] = 1'b1;
      @(negedge clk);
      reprog[0] = 1'b0;
      @(negedge clk);
      chk(loop_phase[0] == 2'b00, "R7 ignored while off", int'(loop_phase[0]), 0);

      // R2: no reference pulses, no progress
      ref_en = 1'b0;
      loop_en[0] = 1'b1;
      repeat (300) @(negedge clk);
      chk(loop_phase[0] == 2'b01, "R2 stalled in tune", int'(loop_phase[0]), 1);
      ref_en = 1'b1;
      run_until(400, 3'b001, 0);
      chk(nrdy[0] == 38 * 7, "R2 resume count", nrdy[0], 38 * 7);

      // R11: two loops with different R run side by side
      all_off();
      r_val[1] = 13'd8;  gain[1] = 2'd1;
      r_val[2] = 13'd10; gain[2] = 2'd2;
      loop_en = 3'b110;
      run_until(1000, 3'b110, 1);
      chk(nrdy[1] == 1 + 38 * 8, "R11 loop1 ready", nrdy[1], 1 + 38 * 8);
      chk(nrdy[2] == 1 + 38 * 10, "R11 loop2 ready", nrdy[2], 1 + 38 * 10);
      chk(nrdy[0] == -1, "R11 loop0 untouched", nrdy[0], -1);

      finish_run();
   end

endmodule